// File: doc/BRIEF.md
# Fixed-Priority Bus Arbiter with Lock Retention

This block decides which of several bus masters owns a shared bus. Each master drives one request bit and one lock bit. The master's position in the vectors is also its priority number, and a smaller number means a higher priority. On every cycle where the arbitration strobe is high, the block picks exactly one requesting master. It drives a registered one-hot grant, the winner's index and a valid flag. These outputs hold their values until the next strobe.

A master can claim the bus for a locked burst by raising its lock bit. If that master wins, the block records the winning index and the lock bit. On the next arbitration, if the recorded master is requesting again, it keeps the bus ahead of any higher-priority requester. This retention ends as soon as that master is granted a request without lock, or is absent when arbitration happens. In every other case, the lowest-numbered requester wins. Reset clears the record.

Top module: `arb_lock_top`

## Requirements
- R1: While reset is high, and on the first cycle after it, grant is all zeros, grant_valid is 0 and grant_idx is 0.
- R2: When no lock retention applies, a strobe grants the requester with the lowest index. A lock bit raised by a master that does not hold a locked record does not change the outcome.
- R3: grant is one-hot with bit i meaning master i, and grant_idx equals i. A strobe with no request bit set gives grant all zeros, grant_valid 0 and grant_idx 0.
- R4: grant, grant_idx and grant_valid change only on the clock edge after a cycle where arb_strobe is high. Request changes without a strobe have no effect on them.
- R5: If the last grant was given with its lock bit set and that master requests at a strobe, it is granted ahead of all lower-numbered requesters.
- R6: A retained master that requests without lock is still granted. The next strobe after that uses plain priority.
- R7: If the locked master is not requesting at a strobe, plain priority decides, and retention does not return later.
- R8: The record of the last winner and its lock bit is updated only by a strobe that produces a grant. A strobe with no requests leaves a locked record in force.
- R9: Reset clears the record, so the first arbitration after reset uses plain priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arb_strobe | input | 1 | Arbitrate on this cycle |
| req | input | NUM_MASTERS | Request bit per master |
| lock | input | NUM_MASTERS | Lock bit per master, meaningful with req |
| grant | output | NUM_MASTERS | Registered one-hot grant |
| grant_idx | output | $clog2(NUM_MASTERS) | Index (priority number) of the granted master |
| grant_valid | output | 1 | A master is currently granted |

## Verification
Lock retention and fixed-priority selection can both apply in the same strobe. This happens when the master holding a locked record requests again while a lower-numbered master also requests. The bench provokes this by first granting a high-numbered master with lock. It then strobes with that master and master 0 requesting together. The result is judged correct only if the grant stays with the retained master. The following strobe must return to master 0 once the holder has re-requested without lock.

// File: rtl/arb_lock_pkg.sv
package arb_lock_pkg;
  // Which rule produced the winner of an arbitration
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_PRIO = 2'd1,
    SRC_HOLD = 2'd2
  } arb_src_e;
endpackage

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
  parameter int NUM_MASTERS = 8,
  localparam int IDX_W = $clog2(NUM_MASTERS)
) (
  input  logic [NUM_MASTERS-1:0] req,
  output logic                   found,
  output logic [IDX_W-1:0]       idx
);
  // Lowest set bit wins; scan downward so the last hit is the lowest index
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_MASTERS - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/arb_lock_tracker.sv
module arb_lock_tracker #(
  parameter int NUM_MASTERS = 8,
  localparam int IDX_W = $clog2(NUM_MASTERS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_lock,
  output logic             rec_valid,
  output logic [IDX_W-1:0] rec_idx,
  output logic             rec_locked
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rec_valid  <= 1'b0;
      rec_idx    <= '0;
      rec_locked <= 1'b0;
    end else if (upd) begin
      rec_valid  <= 1'b1;
      rec_idx    <= upd_idx;
      rec_locked <= upd_lock;
    end
  end
endmodule

// File: rtl/arb_lock_top.sv
module arb_lock_top #(
  parameter int NUM_MASTERS = 8,
  localparam int IDX_W = $clog2(NUM_MASTERS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   arb_strobe,
  input  logic [NUM_MASTERS-1:0] req,
  input  logic [NUM_MASTERS-1:0] lock,
  output logic [NUM_MASTERS-1:0] grant,
  output logic [IDX_W-1:0]       grant_idx,
  output logic                   grant_valid
);
  import arb_lock_pkg::*;

  logic             pick_found;
  logic [IDX_W-1:0] pick_idx;
  logic             rec_valid;
  logic [IDX_W-1:0] rec_idx;
  logic             rec_locked;
  logic             hold;
  arb_src_e         src;
  logic [IDX_W-1:0] win_idx;
  logic             do_grant;

  arb_prio_pick #(.NUM_MASTERS(NUM_MASTERS)) u_pick (
    .req   (req),
    .found (pick_found),
    .idx   (pick_idx)
  );

  // Retention: last winner was locked and is asking again
  assign hold = rec_valid && rec_locked && req[rec_idx];

  always_comb begin
    if (hold) begin
      src     = SRC_HOLD;
      win_idx = rec_idx;
    end else if (pick_found) begin
      src     = SRC_PRIO;
      win_idx = pick_idx;
    end else begin
      src     = SRC_NONE;
      win_idx = '0;
    end
  end

  assign do_grant = arb_strobe && (src != SRC_NONE);

  arb_lock_tracker #(.NUM_MASTERS(NUM_MASTERS)) u_track (
    .clk        (clk),
    .rst        (rst),
    .upd        (do_grant),
    .upd_idx    (win_idx),
    .upd_lock   (lock[win_idx]),
    .rec_valid  (rec_valid),
    .rec_idx    (rec_idx),
    .rec_locked (rec_locked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant       <= '0;
      grant_idx   <= '0;
      grant_valid <= 1'b0;
    end else if (arb_strobe) begin
      grant       <= do_grant ? (NUM_MASTERS'(1) << win_idx) : '0;
      grant_idx   <= win_idx;
      grant_valid <= do_grant;
    end
  end
endmodule

// File: rtl/arb_lock_chk.sv
module arb_lock_chk #(
  parameter int NUM_MASTERS = 8,
  localparam int IDX_W = $clog2(NUM_MASTERS)
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   arb_strobe,
  input logic [NUM_MASTERS-1:0] req,
  input logic [NUM_MASTERS-1:0] grant,
  input logic [IDX_W-1:0]       grant_idx,
  input logic                   grant_valid,
  input logic                   rec_valid,
  input logic [IDX_W-1:0]       rec_idx,
  input logic                   rec_locked
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (grant == '0) && !grant_valid);

  assert_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant) && (grant_valid == (grant != '0)));

  assert_idx_match_R3: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> grant[grant_idx]);

  assert_hold_between_R4: assert property (@(posedge clk) disable iff (rst)
    !arb_strobe |=> $stable(grant) && $stable(grant_idx) && $stable(grant_valid));

  assert_retain_R5: assert property (@(posedge clk) disable iff (rst)
    (arb_strobe && rec_valid && rec_locked && req[rec_idx])
      |=> grant_valid && (grant_idx == $past(rec_idx)));

  assert_record_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    !(arb_strobe && (req != '0))
      |=> $stable(rec_idx) && $stable(rec_locked) && $stable(rec_valid));
endmodule

bind arb_lock_top arb_lock_chk #(.NUM_MASTERS(NUM_MASTERS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .arb_strobe  (arb_strobe),
  .req         (req),
  .grant       (grant),
  .grant_idx   (grant_idx),
  .grant_valid (grant_valid),
  .rec_valid   (rec_valid),
  .rec_idx     (rec_idx),
  .rec_locked  (rec_locked)
);

// File: tb/arb_lock_top_tb.sv
`timescale 1ns/1ps
module arb_lock_top_tb;
  localparam int N = 8;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          arb_strobe = 1'b0;
  logic [N-1:0]  req = '0;
  logic [N-1:0]  lock = '0;
  logic [N-1:0]  grant;
  logic [IW-1:0] grant_idx;
  logic          grant_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  arb_lock_top #(.NUM_MASTERS(N)) u_dut (
    .clk(clk), .rst(rst), .arb_strobe(arb_strobe), .req(req), .lock(lock),
    .grant(grant), .grant_idx(grant_idx), .grant_valid(grant_valid)
  );

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic expect_grant(input string tag, input int idx);
    check({tag, " grant"}, int'(grant), 1 << idx);
    check({tag, " idx"}, int'(grant_idx), idx);
    check({tag, " valid"}, int'(grant_valid), 1);
  endtask

  // Drive one strobe at a falling edge; results are visible one edge later
  task automatic arb(input logic [N-1:0] r, input logic [N-1:0] l);
    @(negedge clk);
    req = r; lock = l; arb_strobe = 1'b1;
    @(negedge clk);
    arb_strobe = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req = '0; lock = '0; arb_strobe = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 grant", int'(grant), 0);
    check("R1 valid", int'(grant_valid), 0);
    check("R1 idx", int'(grant_idx), 0);
  endtask

  task automatic t_prio();
    arb(8'b1010_0100, 8'h00); expect_grant("R2 mixed", 2);
    arb(8'b1000_0000, 8'h00); expect_grant("R2 top", 7);
    arb(8'b1111_1111, 8'h00); expect_grant("R2 all", 0);
    // lock bit on a non-holder does not beat priority
    arb(8'b0000_1010, 8'b0000_1000); expect_grant("R2 lock non-holder", 1);
  endtask

  task automatic t_empty();
    arb(8'h00, 8'h00);
    check("R3 empty grant", int'(grant), 0);
    check("R3 empty valid", int'(grant_valid), 0);
    check("R3 empty idx", int'(grant_idx), 0);
  endtask

  task automatic t_stable();
    arb(8'b0000_0100, 8'h00); expect_grant("R4 setup", 2);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      req = 8'h01 << k; lock = 8'hFF;
    end
    @(negedge clk);
    expect_grant("R4 no strobe", 2);
  endtask

  task automatic t_lock_hold();
    arb(8'b0010_0000, 8'b0010_0000); expect_grant("R5 lock win", 5);
    arb(8'b0010_0011, 8'h00); expect_grant("R5 R6 retained", 5);
    arb(8'b0010_0011, 8'h00); expect_grant("R6 released", 0);
  endtask

  task automatic t_lock_drop();
    arb(8'b0001_0000, 8'b0001_0000); expect_grant("R7 lock win", 4);
    arb(8'b0000_0010, 8'h00); expect_grant("R7 absent", 1);
    arb(8'b0001_0010, 8'h00); expect_grant("R7 no return", 1);
  endtask

  task automatic t_hold_empty();
    arb(8'b0100_0000, 8'b0100_0000); expect_grant("R8 lock win", 6);
    arb(8'h00, 8'h00);
    check("R8 empty grant", int'(grant), 0);
    arb(8'b0100_1000, 8'h00); expect_grant("R8 kept", 6);
  endtask

  task automatic t_reset_clears();
    arb(8'b1000_0000, 8'b1000_0000); expect_grant("R9 lock win", 7);
    do_reset();
    arb(8'b1000_0100, 8'h00); expect_grant("R9 after reset", 2);
  endtask

  initial begin
    t_reset();
    t_prio();
    t_empty();
    t_stable();
    t_lock_hold();
    t_lock_drop();
    t_hold_empty();
    t_reset_clears();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule